// File: doc/BRIEF.md
# Barrel Shifter Operand Unit

This block forms the second ALU operand and the shifter carry-out for a 32-bit RISC data-processing instruction. It takes the instruction word, the value already read for the shifted register, the value already read for the shift-amount register, one flag for each of those two registers saying it is the program counter, and the current carry flag. It returns the shifted operand, the carry the shifter produces, and a flag that tells the pipeline the instruction needs one extra cycle.

Four shift kinds are covered: logical left, logical right, arithmetic right and rotate right. Each can take its amount from a 5-bit field in the instruction or from the low byte of a register. Rotate-right-extended, a 33-bit rotate through the carry, is encoded as an immediate rotate of zero. Several encodings and amounts have special meanings, and those corner cases are the reason the block exists as its own unit.

The block is purely combinational. Register-file reads, the rotated 8-bit immediate operand form and the ALU itself are handled elsewhere.

Top module: `bsh_operand_unit`

## Requirements
- R1: Instruction bit 4 selects the amount source (0 = immediate, 1 = register). Bits 6:5 select the kind (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). Bits 11:7 hold the immediate amount. Bits 31:12 and 3:0 do not affect any output.
- R2: `extra_cycle` is 1 exactly when bit 4 is 1.
- R3: In register form, only bits 7:0 of the adjusted shift-amount value set the amount. Higher bits are ignored.
- R4: In register form, a register flagged as the program counter is used at its value plus 4. This applies to the shifted register and to the amount register. In immediate form the flag has no effect.
- R5: A register amount of 0, of any kind, and an immediate logical-left amount of 0 both return the shifted register unchanged, with carry-out equal to `carry_in`.
- R6: For amounts 1 to 31, the result is the shift or rotate. The carry-out is the last bit shifted out: bit 32-n for left shifts, bit n-1 for right shifts and rotates.
- R7: Register-form logical left by exactly 32 gives 0 with carry equal to bit 0. Logical right by exactly 32 gives 0 with carry equal to bit 31.
- R8: Register-form logical left or right by an amount above 32 gives 0 with carry 0.
- R9: An immediate amount of 0 for logical right means a shift by 32, giving 0 with carry equal to bit 31. For arithmetic right it means a shift by 32, filling every bit with bit 31 and setting carry to bit 31.
- R10: Register-form arithmetic right by 32 or more gives all ones with carry 1 when bit 31 is set, and 0 with carry 0 when it is clear.
- R11: An immediate rotate of 0 gives `{carry_in, value[31:1]}` with carry-out equal to value bit 0.
- R12: Register-form rotate uses the amount modulo 32. A nonzero amount that is a multiple of 32 returns the value unchanged, with carry equal to bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Data-processing instruction word |
| rm_val | input | 32 | Value of the register being shifted |
| rs_val | input | 32 | Value of the register holding the shift amount |
| rm_is_pc | input | 1 | Shifted register is the program counter |
| rs_is_pc | input | 1 | Amount register is the program counter |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted second operand |
| carry_out | output | 1 | Shifter carry-out |
| extra_cycle | output | 1 | Instruction takes one extra cycle |

## Verification
Each kind is driven in both forms at amounts 0, 1, 7, 31, 32, 33, 64 and 255. The data patterns have distinct top and bottom bits, so a carry taken from the wrong end, or a sign fill taken from the wrong bit, shows up as a mismatch. Amount-register values whose low byte is 0, 4 or 32 while the upper bits are set separate true byte truncation from a full-width compare. The program-counter flags are exercised in both forms, including a low byte of 252 that wraps to 0 after the offset, so that an offset applied in the wrong form or before the truncation is detected. A pseudo-random sweep then compares against an independent bit-at-a-time shift model.

// File: rtl/bsh_pkg.sv
// Package: bsh_pkg
// Shared encodings and types for the barrel shifter operand unit.
// Assumes the instruction field positions used by the shift decoder.
package bsh_pkg;

    // width of the register-specified shift amount actually honoured
    localparam int SH_AMT_W   = 8;
    // instruction field positions
    localparam int SRC_BIT    = 4;
    localparam int KIND_LSB   = 5;
    localparam int IMM_LSB    = 7;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    // normalised shift request handed from decode to datapath
    typedef struct packed {
        shift_kind_e         kind;
        logic                reg_form;
        logic                rrx;
        logic [SH_AMT_W-1:0] amount;
    } shift_req_t;

endpackage

// File: rtl/bsh_decode.sv
// Module: bsh_decode
// Splits the instruction into a normalised shift request.
// Selects immediate or register amount, maps the immediate-zero
// encodings (LSR/ASR by 32, ROR as RRX) and applies the PC read offset
// in register form only.
// Assumes DATA_W is a power of two smaller than 2**SH_AMT_W.
module bsh_decode
    import bsh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32,
    parameter int PC_ADJ  = 4
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rm_val,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic               rm_is_pc,
    input  logic               rs_is_pc,
    output shift_req_t         req,
    output logic [DATA_W-1:0]  src_val,
    output logic               extra_cycle
);

    localparam int IMM_W = $clog2(DATA_W);
    localparam logic [SH_AMT_W-1:0] FULL_AMT = SH_AMT_W'(DATA_W);

    logic [IMM_W-1:0]    imm_amt;
    logic [SH_AMT_W-1:0] rs_amt;
    shift_kind_e         kind;
    logic                reg_form;

    // bits that carry no meaning for the shifter
    logic unused_instr;
    logic unused_rs_hi;
    assign unused_instr = ^{instr[INSTR_W-1:IMM_LSB+IMM_W], instr[3:0]};
    assign unused_rs_hi = ^rs_val[DATA_W-1:SH_AMT_W];

    assign imm_amt  = instr[IMM_LSB +: IMM_W];
    assign kind     = shift_kind_e'(instr[KIND_LSB +: 2]);
    assign reg_form = instr[SRC_BIT];

    // low byte of the amount register, with PC offset folded in
    assign rs_amt = rs_val[SH_AMT_W-1:0] + (rs_is_pc ? SH_AMT_W'(PC_ADJ) : '0);

    // register form costs one extra cycle
    assign extra_cycle = reg_form;

    // build the normalised request and the value to shift
    always_comb begin
        req.kind     = kind;
        req.reg_form = reg_form;
        req.rrx      = 1'b0;
        req.amount   = '0;
        src_val      = rm_val;
        if (reg_form) begin
            req.amount = rs_amt;
            src_val    = rm_val + (rm_is_pc ? DATA_W'(PC_ADJ) : '0);
        end else if (imm_amt != '0) begin
            req.amount = SH_AMT_W'(imm_amt);
        end else begin
            unique case (kind)
                SH_LSR, SH_ASR: req.amount = FULL_AMT;
                SH_ROR:         req.rrx    = 1'b1;
                default:        req.amount = '0;
            endcase
        end
    end

endmodule

// File: rtl/bsh_rotator.sv
// Module: bsh_rotator
// Logarithmic right rotator: one mux stage per amount bit.
// Left shifts are served by rotating right by the two's complement
// of the amount. Assumes DATA_W is a power of two.
module bsh_rotator #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  amt,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [IDX_W+1];

    assign stage[0] = din;

    // each stage rotates by a power of two when its amount bit is set
    for (genvar s = 0; s < IDX_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s]
            ? ((stage[s] >> STEP) | (stage[s] << (DATA_W - STEP)))
            : stage[s];
    end

    assign dout = stage[IDX_W];

endmodule

// File: rtl/bsh_mask_gen.sv
// Module: bsh_mask_gen
// Thermometer mask that keeps the bits a shift of amt retains.
// Right: bits below DATA_W-amt. Left: bits at or above amt.
// Assumes amt is within 0..DATA_W-1.
module bsh_mask_gen #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  amt,
    input  logic              left,
    output logic [DATA_W-1:0] keep
);

    // one comparator per output bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign keep[i] = left ? (i >= int'(amt))
                              : ((i + int'(amt)) < DATA_W);
    end

endmodule

// File: rtl/bsh_resolve.sv
// Module: bsh_resolve
// Picks the final operand and carry from the rotated value, the mask
// and the special cases: zero amount, amounts of DATA_W and above,
// sign fill, rotate by a multiple of DATA_W, and RRX.
// Assumes rotated = src rotated right by the low amount bits (left
// shifts: by their negation) and keep from bsh_mask_gen.
module bsh_resolve
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  shift_req_t        req,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] rotated,
    input  logic [DATA_W-1:0] keep,
    input  logic              carry_in,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out
);

    localparam logic [SH_AMT_W-1:0] FULL_AMT = SH_AMT_W'(DATA_W);

    logic [IDX_W-1:0]  n_low;
    logic [IDX_W-1:0]  carry_idx;
    logic              n_zero;
    logic              n_full;
    logic              n_wide;
    logic              sign;
    logic              last_out;
    logic [DATA_W-1:0] sign_fill;

    assign n_low     = req.amount[IDX_W-1:0];
    assign n_zero    = (req.amount == '0);
    assign n_full    = (req.amount == FULL_AMT);
    assign n_wide    = (req.amount >= FULL_AMT);
    assign sign      = src_val[DATA_W-1];
    assign sign_fill = {DATA_W{sign}};

    // index of the last bit shifted out for amounts 1..DATA_W-1
    assign carry_idx = (req.kind == SH_LSL) ? (IDX_W'(0) - n_low)
                                            : (n_low - IDX_W'(1));
    assign last_out  = src_val[carry_idx];

    // select result and carry by kind and amount range
    always_comb begin
        operand   = src_val;
        carry_out = carry_in;
        if (req.rrx) begin
            operand   = {carry_in, src_val[DATA_W-1:1]};
            carry_out = src_val[0];
        end else if (!n_zero) begin
            unique case (req.kind)
                SH_LSL: begin
                    if (n_wide) begin
                        operand   = '0;
                        carry_out = n_full & src_val[0];
                    end else begin
                        operand   = rotated & keep;
                        carry_out = last_out;
                    end
                end
                SH_LSR: begin
                    if (n_wide) begin
                        operand   = '0;
                        carry_out = n_full & sign;
                    end else begin
                        operand   = rotated & keep;
                        carry_out = last_out;
                    end
                end
                SH_ASR: begin
                    if (n_wide) begin
                        operand   = sign_fill;
                        carry_out = sign;
                    end else begin
                        operand   = (rotated & keep) | (sign_fill & ~keep);
                        carry_out = last_out;
                    end
                end
                default: begin
                    if (n_low == '0) begin
                        operand   = src_val;
                        carry_out = sign;
                    end else begin
                        operand   = rotated;
                        carry_out = last_out;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/bsh_operand_unit.sv
// Module: bsh_operand_unit
// Top of the barrel shifter operand unit. Combinational: decode, one
// shared rotator, a mask generator and the special-case resolver.
// Assumes register values are already read and PC flags supplied by
// the register-read stage.
module bsh_operand_unit
    import bsh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32,
    parameter int PC_ADJ  = 4,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rm_val,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic               rm_is_pc,
    input  logic               rs_is_pc,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  operand,
    output logic               carry_out,
    output logic               extra_cycle
);

    shift_req_t        req;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] keep;
    logic [IDX_W-1:0]  n_low;
    logic [IDX_W-1:0]  rot_amt;
    logic              left;

    bsh_decode #(
        .DATA_W  (DATA_W),
        .INSTR_W (INSTR_W),
        .PC_ADJ  (PC_ADJ)
    ) u_decode (
        .instr       (instr),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .rm_is_pc    (rm_is_pc),
        .rs_is_pc    (rs_is_pc),
        .req         (req),
        .src_val     (src_val),
        .extra_cycle (extra_cycle)
    );

    // left shifts rotate right by the negated amount
    assign n_low   = req.amount[IDX_W-1:0];
    assign left    = (req.kind == SH_LSL);
    assign rot_amt = left ? (IDX_W'(0) - n_low) : n_low;

    bsh_rotator #(.DATA_W(DATA_W)) u_rot (
        .din  (src_val),
        .amt  (rot_amt),
        .dout (rotated)
    );

    bsh_mask_gen #(.DATA_W(DATA_W)) u_mask (
        .amt  (n_low),
        .left (left),
        .keep (keep)
    );

    bsh_resolve #(.DATA_W(DATA_W)) u_resolve (
        .req       (req),
        .src_val   (src_val),
        .rotated   (rotated),
        .keep      (keep),
        .carry_in  (carry_in),
        .operand   (operand),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/bsh_operand_checker.sv
// Module: bsh_operand_checker
// Port-level checks for bsh_operand_unit, bound into every instance.
// The block has no clock, so the checks are immediate assertions
// evaluated whenever the ports settle.
module bsh_operand_checker
    import bsh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32
) (
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  rm_val,
    input logic [DATA_W-1:0]  rs_val,
    input logic               rm_is_pc,
    input logic               rs_is_pc,
    input logic               carry_in,
    input logic [DATA_W-1:0]  operand,
    input logic               carry_out,
    input logic               extra_cycle
);

    localparam logic [SH_AMT_W-1:0] FULL_AMT = SH_AMT_W'(DATA_W);

    logic                reg_form;
    logic [1:0]          kind;
    logic [4:0]          imm;
    logic [SH_AMT_W-1:0] rs_lo;

    assign reg_form = instr[SRC_BIT];
    assign kind     = instr[KIND_LSB +: 2];
    assign imm      = instr[IMM_LSB +: 5];
    assign rs_lo    = rs_val[SH_AMT_W-1:0];

    // port relations that hold for every legal input
    always_comb begin
        p_extra_cycle_r2: assert (extra_cycle == reg_form)
            else $error("extra_cycle does not follow the amount source");

        if (reg_form && !rs_is_pc && !rm_is_pc && rs_lo == '0)
            p_zero_amount_r5: assert (operand == rm_val && carry_out == carry_in)
                else $error("zero register amount altered the operand");

        if (reg_form && !rs_is_pc && kind[1] == 1'b0 && rs_lo > FULL_AMT)
            p_wide_logical_r8: assert (operand == '0 && !carry_out)
                else $error("wide logical shift not cleared");

        if (reg_form && !rs_is_pc && !rm_is_pc && kind == 2'b10 && rs_lo >= FULL_AMT)
            p_asr_fill_r10: assert (operand == {DATA_W{rm_val[DATA_W-1]}}
                                    && carry_out == rm_val[DATA_W-1])
                else $error("wide arithmetic shift not sign filled");

        if (!reg_form && kind == 2'b11 && imm == '0)
            p_rrx_r11: assert (operand == {carry_in, rm_val[DATA_W-1:1]}
                               && carry_out == rm_val[0])
                else $error("rotate-extended result wrong");
    end

endmodule

bind bsh_operand_unit bsh_operand_checker #(
    .DATA_W  (DATA_W),
    .INSTR_W (INSTR_W)
) u_chk (
    .instr       (instr),
    .rm_val      (rm_val),
    .rs_val      (rs_val),
    .rm_is_pc    (rm_is_pc),
    .rs_is_pc    (rs_is_pc),
    .carry_in    (carry_in),
    .operand     (operand),
    .carry_out   (carry_out),
    .extra_cycle (extra_cycle)
);

// File: tb/sim_bsh_operand_unit.sv
`timescale 1ns/1ps
// Directed bench for bsh_operand_unit. Each task drives one scenario
// and checks against a bit-at-a-time shift model.
module sim_bsh_operand_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        rm_is_pc = 1'b0;
    logic        rs_is_pc = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;
    logic        extra_cycle;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [19:0] upper_bits = 20'hE1A05;

    always #10 clk = ~clk;

    bsh_operand_unit u0 (
        .instr       (instr),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .rm_is_pc    (rm_is_pc),
        .rs_is_pc    (rs_is_pc),
        .carry_in    (carry_in),
        .operand     (operand),
        .carry_out   (carry_out),
        .extra_cycle (extra_cycle)
    );

    // reference: shift one bit at a time, tracking the bit that falls out
    function automatic logic [32:0] ref_model(input logic [1:0] kind, input logic regf,
                                               input logic [4:0] imm5, input logic [31:0] rm,
                                               input logic [31:0] rs, input logic rmpc,
                                               input logic rspc, input logic cin);
        logic [31:0] v = rm;
        logic        c = cin;
        int          n;
        logic [31:0] rs_adj;
        if (regf) begin
            if (rmpc) v = v + 32'd4;
            rs_adj = rs + (rspc ? 32'd4 : 32'd0);
            n = int'(rs_adj[7:0]);
        end else begin
            n = int'(imm5);
            if (n == 0 && (kind == 2'b01 || kind == 2'b10)) n = 32;
            if (n == 0 && kind == 2'b11) return {cin, v[31:1], v[0]};
        end
        for (int i = 0; i < n; i++) begin
            case (kind)
                2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {v, c};
    endfunction

    // drive one case after a rising edge, check at the falling edge
    task automatic run_case(input string tag, input logic [1:0] kind, input logic regf,
                            input logic [4:0] imm5, input logic [31:0] rm, input logic [31:0] rs,
                            input logic rmpc, input logic rspc, input logic cin);
        logic [32:0] exp;
        @(posedge clk);
        instr    <= regf ? {upper_bits, 4'h9, 1'b0, kind, 1'b1, 4'h3}
                         : {upper_bits, imm5, kind, 1'b0, 4'h3};
        rm_val   <= rm;
        rs_val   <= rs;
        rm_is_pc <= rmpc;
        rs_is_pc <= rspc;
        carry_in <= cin;
        exp = ref_model(kind, regf, imm5, rm, rs, rmpc, rspc, cin);
        @(negedge clk);
        tests++;
        if (operand !== exp[32:1] || carry_out !== exp[0] || extra_cycle !== regf) begin
            fails++;
            $display("FAIL %s kind=%0d reg=%0b: got op=%h c=%b x=%b, expected op=%h c=%b x=%b",
                     tag, kind, regf, operand, carry_out, extra_cycle, exp[32:1], exp[0], regf);
        end
    endtask

    // R5: outputs with all-zero inputs during reset
    task automatic t_reset_state;
        @(negedge clk);
        tests++;
        if (operand !== 32'h0 || carry_out !== 1'b0 || extra_cycle !== 1'b0) begin
            fails++;
            $display("FAIL R5 reset: got op=%h c=%b x=%b, expected op=0 c=0 x=0",
                     operand, carry_out, extra_cycle);
        end
    endtask

    // R6 R9 R5 R11: immediate amounts for every kind
    task automatic t_imm_amounts;
        logic [31:0] pats [3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_3C3C};
        int          amts [4] = '{0, 1, 7, 31};
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 4; a++)
                for (int p = 0; p < 3; p++)
                    run_case(amts[a] == 0 ? (k == 0 ? "R5" : (k == 3 ? "R11" : "R9")) : "R6",
                             2'(k), 1'b0, 5'(amts[a]), pats[p], 32'h0, 1'b0, 1'b0, 1'(p));
    endtask

    // R7 R8 R10 R12 R5: register amounts including 32 and above
    task automatic t_reg_amounts;
        logic [31:0] pats [3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hC000_0002};
        int          amts [7] = '{0, 1, 31, 32, 33, 64, 255};
        string       tags [4] = '{"R7", "R8", "R10", "R12"};
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 7; a++)
                for (int p = 0; p < 3; p++)
                    run_case(amts[a] == 0 ? "R5" : (amts[a] < 32 ? "R6" : tags[k]),
                             2'(k), 1'b1, 5'd0, pats[p], 32'(amts[a]), 1'b0, 1'b0, 1'(a));
    endtask

    // R3: upper bits of the amount register are ignored
    task automatic t_rs_high_bits;
        logic [31:0] rsv [3] = '{32'hFFFF_FF00, 32'h0000_0104, 32'h1234_5620};
        for (int k = 0; k < 4; k++)
            for (int r = 0; r < 3; r++)
                run_case("R3", 2'(k), 1'b1, 5'd0, 32'h9000_000F, rsv[r], 1'b0, 1'b0, 1'b1);
    endtask

    // R4: program-counter offset in register form only
    task automatic t_pc_offset;
        for (int k = 0; k < 4; k++) begin
            run_case("R4", 2'(k), 1'b1, 5'd0, 32'h0000_1000, 32'd28, 1'b1, 1'b1, 1'b0);
            run_case("R4", 2'(k), 1'b1, 5'd0, 32'hFFFF_FFFC, 32'd252, 1'b1, 1'b1, 1'b1);
            run_case("R4", 2'(k), 1'b0, 5'd4, 32'h0000_1000, 32'd0, 1'b1, 1'b1, 1'b0);
        end
    endtask

    // R1 R2: unrelated instruction bits change nothing; extra cycle follows bit 4
    task automatic t_field_ignore;
        logic [19:0] ups [3] = '{20'h00000, 20'hFFFFF, 20'h5A5A5};
        for (int u = 0; u < 3; u++) begin
            upper_bits = ups[u];
            run_case("R1", 2'b01, 1'b0, 5'd3, 32'hF0F0_1234, 32'h0, 1'b0, 1'b0, 1'b0);
            run_case("R2", 2'b10, 1'b1, 5'd0, 32'hF0F0_1234, 32'd5, 1'b0, 1'b0, 1'b0);
        end
        upper_bits = 20'hE1A05;
    endtask

    // R6: pseudo-random sweep of all forms
    task automatic t_sweep;
        logic [31:0] lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_case("R6", lfsr[6:5], lfsr[4], lfsr[11:7], lfsr ^ 32'h3C3C_A5A5,
                     {24'h0, lfsr[23:16]} | (lfsr[2] ? 32'hAB00_0000 : 32'h0),
                     lfsr[12], lfsr[13], lfsr[14]);
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        repeat (2) @(posedge clk);
        rst_n <= 1'b1;
        t_field_ignore();
        t_imm_amounts();
        t_reg_amounts();
        t_rs_high_bits();
        t_pc_offset();
        t_sweep();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule